// File: doc/BRIEF.md
# Serial BCD to Excess-3 Code Converter

This block turns a four-bit decimal digit that arrives one bit per clock, least significant bit first, into its excess-3 form. The excess-3 form is the digit plus three. The converted bits leave on a single serial output, one bit per clock and least significant bit first. Each output bit appears in the same cycle as the input bit it belongs to. The block is a Mealy machine, so the output depends on both the present state and the present input bit.

The machine has seven states held in three D flip-flops, with the start state at code 000. The next-state and output logic is written as a small sum-of-products array: seven product terms built from the input bit and the three state bits. A group takes exactly four clocks, and the machine is then back in the start state. The next group can therefore follow on the very next clock with no gap.

The caller holds synchronous reset high whenever no group is in flight. It drops reset in the cycle that carries bit 0 of the first group.

Top module: `serial_bcd_xs3`

## Requirements
- R1: When `rst` is high at a rising clock edge, the machine is in its start state (state code 000) in the following cycle. In the start state, `dout` is the inverse of `din`: `din`=0 gives `dout`=1, and `din`=1 gives `dout`=0.
- R2: `dout` is a combinational function of the current state and the current `din`. Within one clock cycle, `dout` follows every change of `din` without waiting for a clock edge.
- R3: A code from 0 to 9 presented on `din` least significant bit first, over four consecutive clocks, produces on `dout` the four bits of (code + 3), least significant bit first, each in the same cycle as the matching input bit.
- R4: After exactly four input bits the machine is back in the start state. A new group can begin on the next clock, and no idle cycle is needed between groups.
- R5: The codes 10 to 15 produce (code + 3) mod 16 on `dout` and also return to the start state after four bits. This covers codes 13, 14 and 15, which put a 1 on `din` in the third-bit state (state code 010). That state then gives `dout`=0 and moves to the start state.
- R6: Asserting `rst` partway through a group abandons that group. The next group then converts correctly from its first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset to the start state |
| din | input | 1 | Serial BCD input, least significant bit first |
| dout | output | 1 | Serial excess-3 output, valid in the same cycle as `din` |

## Verification
The most delicate cycle is the one where the group return and the start of the next group meet. The fourth bit of one group moves the machine back to the start state, and the first bit of the next group is already on `din` in the following cycle. The bench runs all ten decimal digits back to back with no gap. In the first cycle of every group it flips `din` both ways and expects the start-state inverse relation before it checks the real bit 0. A second overlap is the wrap from the third-bit state with `din`=1, which both ends a group and produces the last output bit. Codes 13 to 15 provoke it, and each is judged against (code + 3) mod 16 and then against a clean conversion of the group that follows.

// File: rtl/sbx3_pkg.sv
`timescale 1ns/1ps
package sbx3_pkg;

  // state width and array geometry
  localparam int STW     = 3;
  localparam int IN_W    = STW + 1;   // {din, q1, q2, q3}
  localparam int OUT_W   = STW + 1;   // {dout, d1, d2, d3}
  localparam int N_TERMS = 7;

  // state codes {q1,q2,q3}
  localparam logic [STW-1:0] ST_A     = 3'b000;
  localparam logic [STW-1:0] ST_B     = 3'b100;
  localparam logic [STW-1:0] ST_C     = 3'b101;
  localparam logic [STW-1:0] ST_D     = 3'b111;
  localparam logic [STW-1:0] ST_E     = 3'b110;
  localparam logic [STW-1:0] ST_H     = 3'b011;
  localparam logic [STW-1:0] ST_M     = 3'b010;
  localparam logic [STW-1:0] ST_SPARE = 3'b001;

  // AND-plane personality, term 0 in the low nibble.
  // Literal order per term: bit3 din, bit2 q1, bit1 q2, bit0 q3.
  // t0 q2' | t1 q1 | t2 q1q2q3 | t3 din'q1q3' | t4 din q1'q2' | t5 din'q3' | t6 din q3
  localparam logic [N_TERMS*IN_W-1:0] TERM_CARE =
    {4'b1001, 4'b1001, 4'b1110, 4'b1101, 4'b0111, 4'b0100, 4'b0010};
  localparam logic [N_TERMS*IN_W-1:0] TERM_MATCH =
    {4'b1001, 4'b0000, 4'b1000, 4'b0100, 4'b0111, 4'b0100, 4'b0000};

  // OR-plane personality: output order bit3 dout, bit2 d1, bit1 d2, bit0 d3
  localparam logic [N_TERMS*OUT_W-1:0] TERM_SUMS =
    {4'b1000, 4'b1000, 4'b0001, 4'b0001, 4'b0001, 4'b0010, 4'b0100};

endpackage

// File: rtl/sbx3_and_plane.sv
`timescale 1ns/1ps
module sbx3_and_plane #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 7,
  parameter logic [N_TERM*N_IN-1:0] CARE  = '0,
  parameter logic [N_TERM*N_IN-1:0] MATCH = '0
) (
  input  logic [N_IN-1:0]   lits,
  output logic [N_TERM-1:0] terms
);

  // a term is true when every literal it cares about has its required value
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    assign terms[t] =
      (((lits ^ MATCH[t*N_IN +: N_IN]) & CARE[t*N_IN +: N_IN]) == '0);
  end

endmodule

// File: rtl/sbx3_or_plane.sv
`timescale 1ns/1ps
module sbx3_or_plane #(
  parameter int N_TERM = 7,
  parameter int N_OUT  = 4,
  parameter logic [N_TERM*N_OUT-1:0] MAP = '0
) (
  input  logic [N_TERM-1:0] terms,
  output logic [N_OUT-1:0]  sums
);

  for (genvar o = 0; o < N_OUT; o++) begin : g_sum
    always_comb begin
      sums[o] = 1'b0;
      for (int t = 0; t < N_TERM; t++) begin
        if (terms[t] && MAP[t*N_OUT + o]) sums[o] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sbx3_state_reg.sv
`timescale 1ns/1ps
module sbx3_state_reg #(
  parameter int              W         = 3,
  parameter logic [W-1:0]    RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= RESET_VAL;
    else     q <= d;
  end

endmodule

// File: rtl/serial_bcd_xs3.sv
`timescale 1ns/1ps
module serial_bcd_xs3
  import sbx3_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STW-1:0]     state_q;
  logic [STW-1:0]     plane_next;
  logic [STW-1:0]     state_d;
  logic [IN_W-1:0]    lits;
  logic [N_TERMS-1:0] terms;
  logic [OUT_W-1:0]   sums;

  assign lits = {din, state_q};

  sbx3_and_plane #(
    .N_IN  (IN_W),
    .N_TERM(N_TERMS),
    .CARE  (TERM_CARE),
    .MATCH (TERM_MATCH)
  ) and_i (
    .lits (lits),
    .terms(terms)
  );

  sbx3_or_plane #(
    .N_TERM(N_TERMS),
    .N_OUT (OUT_W),
    .MAP   (TERM_SUMS)
  ) or_i (
    .terms(terms),
    .sums (sums)
  );

  assign dout       = sums[OUT_W-1];
  assign plane_next = sums[STW-1:0];

  // the unused code would otherwise step into the middle of a group
  assign state_d = (state_q == ST_SPARE) ? ST_A : plane_next;

  sbx3_state_reg #(
    .W        (STW),
    .RESET_VAL(ST_A)
  ) st_i (
    .clk(clk),
    .rst(rst),
    .d  (state_d),
    .q  (state_q)
  );

endmodule

// File: rtl/serial_bcd_xs3_chk.sv
`timescale 1ns/1ps
module serial_bcd_xs3_chk
  import sbx3_pkg::*;
(
  input logic           clk,
  input logic           rst,
  input logic           din,
  input logic           dout,
  input logic [STW-1:0] state
);

  // bit position within the current group, counted independently
  logic [1:0] bit_pos;
  always_ff @(posedge clk) begin
    if (rst) bit_pos <= 2'd0;
    else     bit_pos <= bit_pos + 2'd1;
  end

  a_r1_reset_start: assert property (@(posedge clk)
    rst |=> (state == ST_A));

  a_r1_start_inverts: assert property (@(posedge clk) disable iff (rst)
    (state == ST_A) |-> (dout == !din));

  a_r4_fourth_bit_return: assert property (@(posedge clk) disable iff (rst)
    (bit_pos == 2'd3) |=> (state == ST_A));

  a_r4_legal_code: assert property (@(posedge clk) disable iff (rst)
    state != ST_SPARE);

  a_r5_wrap_output: assert property (@(posedge clk) disable iff (rst)
    (state == ST_M && din) |-> !dout);

  a_r5_wrap_next: assert property (@(posedge clk) disable iff (rst)
    (state == ST_M && din) |=> (state == ST_A));

endmodule

bind serial_bcd_xs3 serial_bcd_xs3_chk chk_i (
  .clk  (clk),
  .rst  (rst),
  .din  (din),
  .dout (dout),
  .state(state_q)
);

// File: tb/serial_bcd_xs3_tb_top.sv
`timescale 1ns/1ps
module serial_bcd_xs3_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic dout;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;   // 4 ns period

  serial_bcd_xs3 dut_i (
    .clk (clk),
    .rst (rst),
    .din (din),
    .dout(dout)
  );

  task automatic check(input string tag, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0b exp=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  // park in the start state: reset held across at least one edge
  task automatic park();
    @(negedge clk);
    rst = 1'b1;
    din = 1'b0;
    @(posedge clk);
  endtask

  // one four-bit group, LSB first, no idle cycles; reset dropped on bit 0
  task automatic send_code(input logic [3:0] code, input string tag);
    logic [3:0] want;
    want = code + 4'd3;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      rst = 1'b0;
      if (k == 0) begin
        // R4: start state signature in the first cycle of every group
        din = ~code[0];
        #0.4;
        check("R4", dout, ~din);
      end
      din = code[k];
      #0.4;
      check(tag, dout, want[k]);
    end
  endtask

  task automatic t_reset_state();
    repeat (2) @(posedge clk);
    @(negedge clk);
    din = 1'b0;
    #0.4;
    check("R1", dout, 1'b1);
    din = 1'b1;
    #0.4;
    check("R1", dout, 1'b0);
  endtask

  task automatic t_same_cycle_follow();
    park();
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      din = i[0];
      #0.3;
      check("R2", dout, ~i[0]);
    end
  endtask

  task automatic t_all_digits();
    park();
    for (int d = 0; d < 10; d++) send_code(4'(d), "R3");
  endtask

  task automatic t_invalid_codes();
    park();
    for (int c = 10; c < 16; c++) send_code(4'(c), "R5");
    // group after the wrap path must still convert
    send_code(4'd4, "R5");
  endtask

  task automatic t_reset_mid_group();
    logic [3:0] w;
    park();
    w = 4'd7 + 4'd3;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      rst = 1'b0;
      din = 1'(k == 0 ? 1 : 1);
      #0.4;
      check("R6", dout, w[k]);
    end
    @(negedge clk);
    rst = 1'b1;
    din = 1'b1;
    send_code(4'd2, "R6");
    send_code(4'd9, "R6");
  endtask

  initial begin
    t_reset_state();
    t_same_cycle_follow();
    t_all_digits();
    t_invalid_codes();
    t_reset_mid_group();
    park();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule